// File: doc/BRIEF.md
# Stall-aware fetch thread selector

This block decides, every cycle, which of several hardware threads the fetch stage of a simultaneously multithreaded core reads from. Its base rule favours the thread with the fewest instructions in flight. A candidate filter sits around that rule. When the decode stage finds a load and the dependence predictor expects that load to wait on an older store, it sends the predicted wait time. A short predicted wait is tolerated. A longer one takes the thread out of the candidate set, and that thread's fetch is not started again until the stall is nearly over.

Each removed thread carries a down-counter loaded with the predicted wait. The thread comes back once the counter gets down to the front-end depth. Its fresh instructions then reach execution at about the moment the blocking load issues. A resolution pulse from the execution core brings the thread back at once if it arrives first. Outside the filter the base rule is untouched, so a thread coming back with a small in-flight count tends to win the next selections.

Top module: `fetch_thread_sel`

## Requirements
- R1: Among threads not held out, the selected thread is the one with the smallest in-flight count. Thread i's count is the field inflight_cnt_i[i*CNT_W +: CNT_W], read as an unsigned number.
- R2: Among eligible threads with equal counts, the winner is the first one at or after a rotating pointer, in ascending index order with wrap. After each valid fetch the pointer moves to the selected index plus one.
- R3: A dependence hit for thread i (dep_hit_i[i]=1 with dep_delay_i[i*DELAY_W +: DELAY_W] greater than LENIENT_MAX=5) leaves thread i selectable in the cycle of the hit and holds it out from the next cycle on.
- R4: A dependence hit whose predicted delay is at most LENIENT_MAX=5 never holds the thread out.
- R5: With no resolution and no further hit, a thread held out by a hit with delay D is held out for exactly D-PAROLE_AT cycles after the hit cycle (PAROLE_AT=5), then becomes eligible again.
- R6: A resolve_i[i] pulse in a cycle where thread i is held out makes it eligible in the next cycle.
- R7: A new long-delay hit for a thread that is already held out reloads its counter with the larger of the value still remaining and the new delay, with no decrement in that cycle.
- R8: sel_valid_o is low when fe_stall_i is high or when every thread is held out. Otherwise it is high.
- R9: After reset no thread is held out and the rotating pointer is at thread 0.
- R10: The rotating pointer does not move in a cycle where sel_valid_o is low.
- R11: A long-delay hit and a resolve pulse for the same thread in the same cycle hold the thread out. The hit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_stall_i | input | 1 | Front end cannot accept a fetch this cycle |
| inflight_cnt_i | input | NUM_THREADS*CNT_W | Per-thread in-flight instruction counts |
| dep_hit_i | input | NUM_THREADS | Decoded load of thread i predicted to wait on a store |
| dep_delay_i | input | NUM_THREADS*DELAY_W | Predicted wait in cycles for each thread's hit |
| resolve_i | input | NUM_THREADS | Execution core reports thread i's predicted dependence resolved |
| sel_tid_o | output | TID_W | Selected thread index (0 when nothing is eligible) |
| sel_valid_o | output | 1 | A fetch is issued for sel_tid_o this cycle |

## Verification
A held-out flag that is wrong shows up in the cycle right after the faulty update. The thread with the lowest count is skipped, or it keeps winning when it should be skipped. For that reason the directed tests always give the thread under test the smallest count. A countdown that is off by one moves the first cycle in which that thread is selected again by one cycle, and the bench checks that cycle exactly. A rotating pointer that is wrong or moves during a stall changes the winner of the next tie, which the tie sequences detect within one cycle.

// File: rtl/fts_pkg.sv
package fts_pkg;

   // per-cycle action taken by one thread's hold-out gate
   typedef enum logic [1:0] {
      GATE_IDLE = 2'd0,   // thread eligible, nothing to do
      GATE_LOAD = 2'd1,   // long-delay hit: hold out, (re)load counter
      GATE_FREE = 2'd2,   // core resolved dependence: release now
      GATE_TICK = 2'd3    // held out: count down toward parole
   } gate_cmd_e;

   localparam int unsigned DEF_THREADS     = 4;
   localparam int unsigned DEF_CNT_W       = 8;
   localparam int unsigned DEF_DELAY_W     = 7;
   localparam int unsigned DEF_LENIENT_MAX = 5;
   localparam int unsigned DEF_PAROLE_AT   = 5;

endpackage

// File: rtl/fts_hold_gate.sv
module fts_hold_gate
   import fts_pkg::*;
#(
   parameter int unsigned DELAY_W     = DEF_DELAY_W,
   parameter int unsigned LENIENT_MAX = DEF_LENIENT_MAX,
   parameter int unsigned PAROLE_AT   = DEF_PAROLE_AT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit_i,
   input  logic [DELAY_W-1:0] delay_i,
   input  logic               resolve_i,
   output logic               held_o,
   output logic [DELAY_W-1:0] left_o
);

   localparam logic [DELAY_W-1:0] LEN_V     = DELAY_W'(LENIENT_MAX);
   localparam logic [DELAY_W-1:0] RELEASE_V = DELAY_W'(PAROLE_AT + 1);
   localparam logic [DELAY_W-1:0] ONE_V     = DELAY_W'(1);

   logic               held_q;
   logic [DELAY_W-1:0] left_q;
   logic               heavy;
   gate_cmd_e          cmd;
   logic [DELAY_W-1:0] reload;

   assign heavy  = hit_i && (delay_i > LEN_V);
   assign reload = (held_q && (left_q > delay_i)) ? left_q : delay_i;

   always_comb begin
      if (heavy)          cmd = GATE_LOAD;
      else if (!held_q)   cmd = GATE_IDLE;
      else if (resolve_i) cmd = GATE_FREE;
      else                cmd = GATE_TICK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         left_q <= '0;
      end else begin
         unique case (cmd)
            GATE_LOAD: begin
               held_q <= 1'b1;
               left_q <= reload;
            end
            GATE_FREE: begin
               held_q <= 1'b0;
               left_q <= '0;
            end
            GATE_TICK: begin
               if (left_q <= RELEASE_V) begin
                  held_q <= 1'b0;
                  left_q <= '0;
               end else begin
                  left_q <= left_q - ONE_V;
               end
            end
            default: begin
               held_q <= held_q;
               left_q <= left_q;
            end
         endcase
      end
   end

   assign held_o = held_q;
   assign left_o = left_q;

endmodule

// File: rtl/fts_min_pick.sv
module fts_min_pick
   import fts_pkg::*;
#(
   parameter int unsigned NUM_THREADS = DEF_THREADS,
   parameter int unsigned CNT_W       = DEF_CNT_W,
   parameter bit          ROTATE_TIES = 1'b1,
   localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic [NUM_THREADS-1:0]       elig_i,
   input  logic [NUM_THREADS*CNT_W-1:0] cnt_i,
   input  logic [TID_W-1:0]             ptr_i,
   output logic                         found_o,
   output logic [TID_W-1:0]             tid_o
);

   logic [CNT_W-1:0] cnt_a [NUM_THREADS];
   logic [TID_W-1:0] start;

   for (genvar g = 0; g < NUM_THREADS; g++) begin : g_unpack
      assign cnt_a[g] = cnt_i[g*CNT_W +: CNT_W];
   end

   if (ROTATE_TIES) begin : g_rotate
      assign start = ptr_i;
   end else begin : g_fixed
      logic unused_ptr;
      assign unused_ptr = ^ptr_i;
      assign start = '0;
   end

   logic [TID_W-1:0] cand;
   logic [CNT_W-1:0] best_cnt;

   always_comb begin
      found_o  = 1'b0;
      tid_o    = '0;
      best_cnt = '1;
      cand     = '0;
      for (int k = 0; k < NUM_THREADS; k++) begin
         cand = start + TID_W'(k);
         if (elig_i[cand] && (!found_o || (cnt_a[cand] < best_cnt))) begin
            found_o  = 1'b1;
            tid_o    = cand;
            best_cnt = cnt_a[cand];
         end
      end
   end

endmodule

// File: rtl/fts_rr_ptr.sv
module fts_rr_ptr
   import fts_pkg::*;
#(
   parameter int unsigned NUM_THREADS = DEF_THREADS,
   localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic [TID_W-1:0] last_i,
   output logic [TID_W-1:0] ptr_o
);

   localparam logic [TID_W-1:0] STEP = TID_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)     ptr_o <= '0;
      else if (adv_i) ptr_o <= last_i + STEP;
   end

endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
   import fts_pkg::*;
#(
   parameter int unsigned NUM_THREADS = DEF_THREADS,
   parameter int unsigned CNT_W       = DEF_CNT_W,
   parameter int unsigned DELAY_W     = DEF_DELAY_W,
   parameter int unsigned LENIENT_MAX = DEF_LENIENT_MAX,
   parameter int unsigned PAROLE_AT   = DEF_PAROLE_AT,
   parameter bit          ROTATE_TIES = 1'b1,
   localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           fe_stall_i,
   input  logic [NUM_THREADS*CNT_W-1:0]   inflight_cnt_i,
   input  logic [NUM_THREADS-1:0]         dep_hit_i,
   input  logic [NUM_THREADS*DELAY_W-1:0] dep_delay_i,
   input  logic [NUM_THREADS-1:0]         resolve_i,
   output logic [TID_W-1:0]               sel_tid_o,
   output logic                           sel_valid_o
);

   // elaboration-time parameter checks
   if (NUM_THREADS < 2 || (NUM_THREADS & (NUM_THREADS - 1)) != 0) begin : g_bad_threads
      $error("fetch_thread_sel: NUM_THREADS must be a power of two >= 2");
   end
   if (PAROLE_AT > LENIENT_MAX) begin : g_bad_parole
      $error("fetch_thread_sel: PAROLE_AT must not exceed LENIENT_MAX");
   end
   if (LENIENT_MAX + 1 >= (1 << DELAY_W)) begin : g_bad_delay_w
      $error("fetch_thread_sel: DELAY_W too narrow for LENIENT_MAX");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("fetch_thread_sel: CNT_W must be positive");
   end

   logic [NUM_THREADS-1:0]         excl_q;
   logic [NUM_THREADS*DELAY_W-1:0] cnt_q;
   logic [TID_W-1:0]               rr_ptr;
   logic                           found;
   logic [TID_W-1:0]               pick_tid;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_gate
      fts_hold_gate #(
         .DELAY_W    (DELAY_W),
         .LENIENT_MAX(LENIENT_MAX),
         .PAROLE_AT  (PAROLE_AT)
      ) u_gate (
         .clk      (clk),
         .rst_n    (rst_n),
         .hit_i    (dep_hit_i[t]),
         .delay_i  (dep_delay_i[t*DELAY_W +: DELAY_W]),
         .resolve_i(resolve_i[t]),
         .held_o   (excl_q[t]),
         .left_o   (cnt_q[t*DELAY_W +: DELAY_W])
      );
   end

   fts_min_pick #(
      .NUM_THREADS(NUM_THREADS),
      .CNT_W      (CNT_W),
      .ROTATE_TIES(ROTATE_TIES)
   ) u_pick (
      .elig_i (~excl_q),
      .cnt_i  (inflight_cnt_i),
      .ptr_i  (rr_ptr),
      .found_o(found),
      .tid_o  (pick_tid)
   );

   fts_rr_ptr #(
      .NUM_THREADS(NUM_THREADS)
   ) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (sel_valid_o),
      .last_i(pick_tid),
      .ptr_o (rr_ptr)
   );

   assign sel_valid_o = found && !fe_stall_i;
   assign sel_tid_o   = pick_tid;

endmodule

// File: rtl/fts_checker.sv
module fts_checker
   import fts_pkg::*;
#(
   parameter int unsigned NUM_THREADS = DEF_THREADS,
   parameter int unsigned CNT_W       = DEF_CNT_W,
   parameter int unsigned DELAY_W     = DEF_DELAY_W,
   parameter int unsigned LENIENT_MAX = DEF_LENIENT_MAX,
   parameter int unsigned PAROLE_AT   = DEF_PAROLE_AT,
   localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           fe_stall_i,
   input logic [NUM_THREADS*CNT_W-1:0]   inflight_cnt_i,
   input logic [NUM_THREADS-1:0]         dep_hit_i,
   input logic [NUM_THREADS*DELAY_W-1:0] dep_delay_i,
   input logic [NUM_THREADS-1:0]         resolve_i,
   input logic [TID_W-1:0]               sel_tid_o,
   input logic                           sel_valid_o,
   input logic [NUM_THREADS-1:0]         excl_q,
   input logic [NUM_THREADS*DELAY_W-1:0] cnt_q
);

   localparam logic [DELAY_W-1:0] LEN_V     = DELAY_W'(LENIENT_MAX);
   localparam logic [DELAY_W-1:0] RELEASE_V = DELAY_W'(PAROLE_AT + 1);

   logic [CNT_W-1:0] cnt_a [NUM_THREADS];
   logic [CNT_W-1:0] min_elig;

   for (genvar g = 0; g < NUM_THREADS; g++) begin : g_cnt
      assign cnt_a[g] = inflight_cnt_i[g*CNT_W +: CNT_W];
   end

   always_comb begin
      min_elig = '1;
      for (int k = 0; k < NUM_THREADS; k++) begin
         if (!excl_q[k] && cnt_a[k] < min_elig) min_elig = cnt_a[k];
      end
   end

   // R1: winner holds the smallest count among eligible threads
   a_r1_min_count: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid_o |-> (cnt_a[sel_tid_o] == min_elig));

   // R3: a held-out thread is never fetched
   a_r3_no_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid_o |-> !excl_q[sel_tid_o]);

   // R8: fetch-valid follows stall and eligibility
   a_r8_valid_rule: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid_o == (!fe_stall_i && (excl_q != '1)));

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic             heavy;
      logic [DELAY_W-1:0] left;
      assign heavy = dep_hit_i[t] && (dep_delay_i[t*DELAY_W +: DELAY_W] > LEN_V);
      assign left  = cnt_q[t*DELAY_W +: DELAY_W];

      // R3 / R11: long-delay hit holds the thread out, even with resolve
      a_r3_hold_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
         heavy |=> excl_q[t]);

      // R4: short-delay hit leaves an eligible thread eligible
      a_r4_lenient: assert property (@(posedge clk) disable iff (!rst_n)
         (dep_hit_i[t] && !heavy && !excl_q[t]) |=> !excl_q[t]);

      // R6: resolve without a new hit releases
      a_r6_resolve_frees: assert property (@(posedge clk) disable iff (!rst_n)
         (resolve_i[t] && !heavy) |=> !excl_q[t]);

      // R5: release once the counter reaches the parole point
      a_r5_parole_release: assert property (@(posedge clk) disable iff (!rst_n)
         (excl_q[t] && !heavy && !resolve_i[t] && left <= RELEASE_V) |=> !excl_q[t]);

      // R5: no release before the parole point
      a_r5_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
         (excl_q[t] && !heavy && !resolve_i[t] && left > RELEASE_V) |=> excl_q[t]);
   end

endmodule

bind fetch_thread_sel fts_checker #(
   .NUM_THREADS(NUM_THREADS),
   .CNT_W      (CNT_W),
   .DELAY_W    (DELAY_W),
   .LENIENT_MAX(LENIENT_MAX),
   .PAROLE_AT  (PAROLE_AT)
) u_chk (.*);

// File: tb/tb_fetch_thread_sel.sv
module tb_fetch_thread_sel;

   localparam int NT = 4;
   localparam int CW = 8;
   localparam int DW = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fe_stall_i = 1'b0;
   logic [NT*CW-1:0]  inflight_cnt_i = '0;
   logic [NT-1:0]     dep_hit_i = '0;
   logic [NT*DW-1:0]  dep_delay_i = '0;
   logic [NT-1:0]     resolve_i = '0;
   logic [1:0]        sel_tid_o;
   logic              sel_valid_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #4 clk = ~clk;   // 125 MHz

   fetch_thread_sel dut (
      .clk(clk), .rst_n(rst_n), .fe_stall_i(fe_stall_i),
      .inflight_cnt_i(inflight_cnt_i), .dep_hit_i(dep_hit_i),
      .dep_delay_i(dep_delay_i), .resolve_i(resolve_i),
      .sel_tid_o(sel_tid_o), .sel_valid_o(sel_valid_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual=%0d cycles expected<20000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // next cycle: wait for falling edge, drop one-cycle pulses
   task automatic nxt();
      @(negedge clk);
      dep_hit_i = '0;
      resolve_i = '0;
   endtask

   task automatic set_cnt(input int a, input int b, input int c, input int d);
      inflight_cnt_i = {CW'(d), CW'(c), CW'(b), CW'(a)};
   endtask

   task automatic hit(input int t, input int delay);
      dep_hit_i[t] = 1'b1;
      dep_delay_i[t*DW +: DW] = DW'(delay);
   endtask

   task automatic exp_sel(input string tag, input int tid);
      #1;
      chk(sel_valid_o && sel_tid_o == 2'(tid), tag,
          sel_valid_o ? int'(sel_tid_o) : -1, tid);
   endtask

   // thread 2 has the smallest count: valid and not 2 means held out
   task automatic exp_held2(input string tag);
      #1;
      chk(sel_valid_o && sel_tid_o != 2'd2, tag,
          sel_valid_o ? int'(sel_tid_o) : -1, -2);
   endtask

   task automatic exp_invalid(input string tag);
      #1;
      chk(!sel_valid_o, tag, int'(sel_valid_o), 0);
   endtask

   task automatic t_reset();
      set_cnt(5, 5, 5, 5);
      exp_sel("R9 reset: no hold-out, pointer at 0", 0);
   endtask

   task automatic t_min();
      nxt(); set_cnt(7, 9, 2, 8);     exp_sel("R1 min pattern a", 2);
      nxt(); set_cnt(4, 6, 6, 1);     exp_sel("R1 min pattern b", 3);
      nxt(); set_cnt(200, 3, 250, 255); exp_sel("R1 min pattern c", 1);
   endtask

   task automatic t_rr();
      nxt(); set_cnt(9, 9, 9, 0); exp_sel("R1 park pointer", 3);
      nxt(); set_cnt(6, 6, 6, 6); exp_sel("R2 tie 0", 0);
      nxt(); exp_sel("R2 tie 1", 1);
      nxt(); fe_stall_i = 1'b1; exp_invalid("R8 stall blocks fetch");
      nxt(); exp_invalid("R8 stall blocks fetch again");
      nxt(); fe_stall_i = 1'b0; exp_sel("R10 pointer held during stall", 2);
      nxt(); exp_sel("R2 tie 3", 3);
      nxt(); exp_sel("R2 tie wraps to 0", 0);
   endtask

   task automatic t_lenient();
      nxt(); set_cnt(10, 10, 1, 10); hit(2, 5);
      exp_sel("R4 hit cycle with delay 5", 2);
      for (int i = 0; i < 3; i++) begin
         nxt(); exp_sel("R4 delay 5 not held out", 2);
      end
   endtask

   task automatic t_parole();
      nxt(); hit(2, 9); exp_sel("R3 still selectable in hit cycle", 2);
      for (int i = 0; i < 4; i++) begin
         nxt(); exp_held2("R5 held out for delay 9");
      end
      nxt(); exp_sel("R5 paroled after delay 9 minus 5", 2);
      nxt(); hit(2, 6); exp_sel("R3 hit cycle delay 6", 2);
      nxt(); exp_held2("R5 held out one cycle for delay 6");
      nxt(); exp_sel("R5 paroled after delay 6", 2);
   endtask

   task automatic t_resolve();
      nxt(); hit(2, 40); exp_sel("R3 hit cycle delay 40", 2);
      nxt(); exp_held2("R6 held before resolve");
      nxt(); resolve_i[2] = 1'b1; exp_held2("R6 held in resolve cycle");
      nxt(); exp_sel("R6 released after resolve", 2);
   endtask

   task automatic t_refresh();
      nxt(); hit(2, 9); exp_sel("R7 first hit cycle", 2);
      nxt(); exp_held2("R7 held c1");
      nxt(); hit(2, 6); exp_held2("R7 held during second hit");
      for (int i = 0; i < 3; i++) begin
         nxt(); exp_held2("R7 larger remaining count kept");
      end
      nxt(); exp_sel("R7 released after remaining count", 2);
   endtask

   task automatic t_collide();
      nxt(); hit(2, 20); resolve_i[2] = 1'b1; exp_sel("R11 collision cycle", 2);
      nxt(); exp_held2("R11 hit wins over resolve");
      nxt(); resolve_i[2] = 1'b1; exp_held2("R11 still held");
      nxt(); exp_sel("R11 freed by later resolve", 2);
   endtask

   task automatic t_none();
      nxt(); for (int t = 0; t < NT; t++) hit(t, 30);
      exp_sel("R8 all hit cycle", 2);
      nxt(); exp_invalid("R8 all threads held out");
      nxt(); resolve_i = 4'b0001; exp_invalid("R8 still none eligible");
      nxt(); exp_sel("R6 only thread 0 released", 0);
      nxt(); resolve_i = 4'b1110;
      nxt(); exp_sel("R6 thread 2 back with lowest count", 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_min();
      t_rr();
      t_lenient();
      t_parole();
      t_resolve();
      t_refresh();
      t_collide();
      t_none();
      nxt();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule